// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the register file that a host processor sees when it talks to one UART. The host uses an 8-bit parallel bus with a 3-bit address, a write strobe and a read strobe. Read data is combinational: it follows the address and the current bank state in the same cycle. Writes and FIFO pops take effect at the next rising clock edge. Eight addresses are not enough for every register, so a write-only bank register picks which register set the address field decodes to. That register always sits at address 7, whatever set is selected, so software can always get back to the general set.

The general set carries the transmit/receive data port, an 8-bit scratch register, a status byte and an auxiliary slot. The first extra set carries the two bytes of the 16-bit baud divisor, which is also driven out of the block. The second extra set and the reserved selector value expose nothing. Two byte queues, each DEPTH entries deep (128 by default), sit between the host bus and the serial side. The serial side drains the transmit queue and fills the receive queue through their own strobes. When the level-count enable is set in the general set, the status and auxiliary addresses are replaced by two 8-bit counts: free transmit space and receive fill.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the selector is general (00) and level access is off. The divisor output is 0x0001, the scratch register is 0x00 and both queues are empty. So the status byte reads 0x60, the transmit free count reads 128 and the receive count reads 0.
- R2: A write to address 7 in any bank loads the selector from data bits 2:1 and the level enable from bit 0. Bits 7:3 are ignored. A read at address 7 returns 0x00 in every bank.
- R3: In the general set, address 1 is a scratch register that returns the last byte written to it.
- R4: In the first extra set (selector 01), address 0 holds the divisor low byte and address 1 holds the high byte. Both read back, and the 16-bit divisor output is {high, low}.
- R5: In the general set, a write to address 0 appends a byte to the transmit queue. The serial side sees the oldest byte on txOutData, with txOutValid high while the queue is not empty, and removes it with txOutPop. Bytes leave in write order, and a write to a full queue is dropped.
- R6: rxInPush appends a byte to the receive queue, and a push into a full queue is dropped. In the general set, a read at address 0 returns the oldest byte and a read strobe there removes it. Reading an empty queue returns 0x00.
- R7: With level access off, address 5 of the general set returns a status byte. Bit 0 is receive-not-empty, bit 1 is receive-full, bit 5 is transmit-not-full, bit 6 is transmit-empty, and the other bits are 0. Address 6 then reads 0x00.
- R8: With the selector at 00 and level access on, address 5 returns the number of free transmit entries and address 6 returns the number of bytes held in the receive queue. Writes to addresses 5 and 6 change neither value.
- R9: The selector takes priority over the level enable. With the selector not 00, the counts are never returned, even when the enable bit is 1.
- R10: With the selector at 10 or 11, every address except 7 reads 0x00, and writes there change no register or queue.
- R11: Both counts are 8 bits wide and are bounded by 128. A full transmit queue reads a free count of 0, and a full receive queue reads a fill count of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Host register address |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (pops the receive queue at address 0) |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, combinational from address and bank state |
| divisor | output | 16 | Baud divisor {high, low} |
| txOutData | output | 8 | Oldest byte in the transmit queue |
| txOutValid | output | 1 | Transmit queue not empty |
| txOutPop | input | 1 | Serial side removes the oldest transmit byte |
| rxInData | input | 8 | Byte arriving from the serial side |
| rxInPush | input | 1 | Serial side appends rxInData to the receive queue |

## Verification
The assertions assume that wrEn and rdEn are never high in the same cycle. They also assume that the serial-side strobes are only raised when they make sense, and when they do not, they rely on the queues to ignore them. The bench drives every host access as a single one-cycle strobe on a falling edge and keeps at most one host strobe active at a time. It raises txOutPop and rxInPush only inside their own tasks, and it deliberately overfills each queue by one entry and reads an empty receive queue to cover the drop and underflow paths.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIVLO   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIVHI   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_AUX     = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_BANK    = 3'd7;

  typedef enum logic [1:0] {
    BANK_GEN  = 2'b00,
    BANK_EXT1 = 2'b01,
    BANK_EXT2 = 2'b10,
    BANK_RSVD = 2'b11
  } bank_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_RXDATA,
    RD_SCRATCH,
    RD_STATUS,
    RD_TXFREE,
    RD_RXCOUNT,
    RD_DIVLO,
    RD_DIVHI
  } rdsel_e;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic scratchWr;
    logic divLoWr;
    logic divHiWr;
  } strobe_t;

endpackage

// File: rtl/ubr_fifo.sv
module ubr_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           pushEn,
  input  logic [WIDTH-1:0]               pushData,
  input  logic                           popEn,
  output logic [WIDTH-1:0]               headData,
  output logic [$clog2(DEPTH):0]         count,
  output logic                           empty,
  output logic                           full
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] countQ;
  logic             doPush;
  logic             doPop;

  assign empty    = (countQ == '0);
  assign full     = (countQ == FULL_CNT);
  assign doPop    = popEn && !empty;
  assign doPush   = pushEn && (!full || doPop);
  assign headData = empty ? '0 : mem[rdPtr];
  assign count    = countQ;

  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // R11: occupancy never exceeds the queue depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);

  // R5: a push into a full queue with no pop leaves the occupancy alone
  a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushEn && !popEn) |=> (countQ == FULL_CNT));

  // R6: a pop from an empty queue with no push leaves it empty
  a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popEn && !pushEn) |=> (countQ == '0));

endmodule

// File: rtl/ubr_ctrl.sv
module ubr_ctrl
  import ubr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output strobe_t           strobes,
  output rdsel_e            readSel
);

  bank_e bankQ;
  logic  levelQ;
  logic  levelVisible;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= BANK_GEN;
      levelQ <= 1'b0;
    end else if (wrEn && (addr == ADDR_BANK)) begin
      bankQ  <= bank_e'(wrData[2:1]);
      levelQ <= wrData[0];
    end
  end

  // Selector outranks the level enable: counts only show in the general set
  assign levelVisible = (bankQ == BANK_GEN) && levelQ;

  always_comb begin
    strobes = '0;
    readSel = RD_ZERO;
    case (bankQ)
      BANK_GEN: begin
        case (addr)
          ADDR_DATA: begin
            readSel         = RD_RXDATA;
            strobes.txPush  = wrEn;
            strobes.rxPop   = rdEn;
          end
          ADDR_SCRATCH: begin
            readSel           = RD_SCRATCH;
            strobes.scratchWr = wrEn;
          end
          ADDR_STATUS: readSel = levelVisible ? RD_TXFREE : RD_STATUS;
          ADDR_AUX:    readSel = levelVisible ? RD_RXCOUNT : RD_ZERO;
          default:     readSel = RD_ZERO;
        endcase
      end
      BANK_EXT1: begin
        case (addr)
          ADDR_DIVLO: begin
            readSel         = RD_DIVLO;
            strobes.divLoWr = wrEn;
          end
          ADDR_DIVHI: begin
            readSel         = RD_DIVHI;
            strobes.divHiWr = wrEn;
          end
          default: readSel = RD_ZERO;
        endcase
      end
      default: begin
        strobes = '0;
        readSel = RD_ZERO;
      end
    endcase
  end

  // R2: a bank write takes the selector and enable from the data byte
  a_r2_bank_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_BANK)) |=>
      ((bankQ == bank_e'($past(wrData[2:1]))) && (levelQ == $past(wrData[0]))));

  // R10: at most one datapath strobe per cycle
  a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R9: outside the general set the counts are never selected
  a_r9_level_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (bankQ != BANK_GEN) |-> !(readSel inside {RD_TXFREE, RD_RXCOUNT}));

  // R10: empty banks neither return data nor touch state
  a_r10_empty_bank_inert: assert property (@(posedge clk) disable iff (!rstN)
    (bankQ inside {BANK_EXT2, BANK_RSVD}) |-> ((readSel == RD_ZERO) && (strobes == '0)));

endmodule

// File: rtl/ubr_datapath.sv
module ubr_datapath
  import ubr_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  wrData,
  input  strobe_t     strobes,
  input  rdsel_e      readSel,
  output logic [7:0]  rdData,
  output logic [15:0] divisor,
  output logic [7:0]  txOutData,
  output logic        txOutValid,
  input  logic        txOutPop,
  input  logic [7:0]  rxInData,
  input  logic        rxInPush
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int CAP   = (DEPTH > 255) ? 255 : DEPTH;
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_CNT   = CNT_W'(CAP);

  logic [7:0]       scratchQ;
  logic [7:0]       divLoQ;
  logic [7:0]       divHiQ;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;
  logic [CNT_W-1:0] txFree;
  logic             txEmpty;
  logic             txFull;
  logic             rxEmpty;
  logic             rxFull;
  logic [7:0]       rxHead;
  logic [7:0]       statusByte;

  function automatic logic [7:0] countByte(input logic [CNT_W-1:0] v);
    logic [CNT_W+7:0] wide;
    wide = {8'd0, ((v > CAP_CNT) ? CAP_CNT : v)};
    return wide[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchQ <= 8'h00;
      divLoQ   <= 8'h01;
      divHiQ   <= 8'h00;
    end else begin
      if (strobes.scratchWr) scratchQ <= wrData;
      if (strobes.divLoWr)   divLoQ   <= wrData;
      if (strobes.divHiWr)   divHiQ   <= wrData;
    end
  end

  ubr_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strobes.txPush),
    .pushData (wrData),
    .popEn    (txOutPop),
    .headData (txOutData),
    .count    (txCount),
    .empty    (txEmpty),
    .full     (txFull)
  );

  ubr_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (rxInPush),
    .pushData (rxInData),
    .popEn    (strobes.rxPop),
    .headData (rxHead),
    .count    (rxCount),
    .empty    (rxEmpty),
    .full     (rxFull)
  );

  assign txOutValid = !txEmpty;
  assign txFree     = DEPTH_CNT - txCount;
  assign divisor    = {divHiQ, divLoQ};
  assign statusByte = {1'b0, txEmpty, !txFull, 3'b000, rxFull, !rxEmpty};

  always_comb begin
    case (readSel)
      RD_RXDATA:  rdData = rxHead;
      RD_SCRATCH: rdData = scratchQ;
      RD_STATUS:  rdData = statusByte;
      RD_TXFREE:  rdData = countByte(txFree);
      RD_RXCOUNT: rdData = countByte(rxCount);
      RD_DIVLO:   rdData = divLoQ;
      RD_DIVHI:   rdData = divHiQ;
      default:    rdData = 8'h00;
    endcase
  end

  // R4: a low-byte strobe lands in the exported divisor on the next cycle
  a_r4_divlo_export: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divLoWr |=> (divisor[7:0] == $past(wrData)));

  // R4: same for the high byte
  a_r4_divhi_export: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divHiWr |=> (divisor[15:8] == $past(wrData)));

  // R11: free space and fill each stay within the queue depth
  a_r11_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txFree <= DEPTH_CNT) && (rxCount <= DEPTH_CNT));

  // R3: scratch only changes on its own strobe
  a_r3_scratch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.scratchWr |=> $stable(scratchQ));

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import ubr_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [15:0]       divisor,
  output logic [7:0]        txOutData,
  output logic              txOutValid,
  input  logic              txOutPop,
  input  logic [7:0]        rxInData,
  input  logic              rxInPush
);

  strobe_t strobes;
  rdsel_e  readSel;

  ubr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .strobes (strobes),
    .readSel (readSel)
  );

  ubr_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .strobes    (strobes),
    .readSel    (readSel),
    .rdData     (rdData),
    .divisor    (divisor),
    .txOutData  (txOutData),
    .txOutValid (txOutValid),
    .txOutPop   (txOutPop),
    .rxInData   (rxInData),
    .rxInPush   (rxInPush)
  );

endmodule

// File: tb/test_uart_bank_regs.sv
`timescale 1ns/1ps
module test_uart_bank_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] divisor;
  logic [7:0]  txOutData;
  logic        txOutValid;
  logic        txOutPop = 1'b0;
  logic [7:0]  rxInData = '0;
  logic        rxInPush = 1'b0;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  uart_bank_regs i_uart_bank_regs (
    .clk, .rstN, .addr, .wrEn, .rdEn, .wrData, .rdData, .divisor,
    .txOutData, .txOutValid, .txOutPop, .rxInData, .rxInPush
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [2:0] a, input int exp);
    logic [7:0] d;
    hostRead(a, d);
    chk(req, d, exp);
  endtask

  task automatic linePop(output logic [7:0] d, output logic v);
    @(negedge clk);
    #1 d = txOutData; v = txOutValid;
    txOutPop = 1'b1;
    @(negedge clk);
    txOutPop = 1'b0;
  endtask

  task automatic linePush(input logic [7:0] d);
    @(negedge clk);
    rxInData = d; rxInPush = 1'b1;
    @(negedge clk);
    rxInPush = 1'b0;
  endtask

  task automatic testReset;
    chk("R1 divisor", divisor, 16'h0001);
    readChk("R1 scratch", 3'd1, 8'h00);
    readChk("R1/R7 status", 3'd5, 8'h60);
    readChk("R7 aux off", 3'd6, 8'h00);
    readChk("R2 bank read", 3'd7, 8'h00);
    chk("R1 txValid", txOutValid, 0);
    hostWrite(3'd7, 8'h01);
    readChk("R1/R8 txFree", 3'd5, 128);
    readChk("R1/R8 rxCount", 3'd6, 0);
    hostWrite(3'd7, 8'h00);
  endtask

  task automatic testScratch;
    hostWrite(3'd1, 8'hA5);
    readChk("R3 scratch A5", 3'd1, 8'hA5);
    hostWrite(3'd1, 8'h3C);
    readChk("R3 scratch 3C", 3'd1, 8'h3C);
  endtask

  task automatic testDivisor;
    hostWrite(3'd7, 8'h02);
    hostWrite(3'd0, 8'h34);
    hostWrite(3'd1, 8'h12);
    chk("R4 divisor out", divisor, 16'h1234);
    readChk("R4 div low", 3'd0, 8'h34);
    readChk("R4 div high", 3'd1, 8'h12);
    readChk("R2 bank read ext1", 3'd7, 8'h00);
    hostWrite(3'd7, 8'hFA);
    readChk("R2 upper bits ignored", 3'd0, 8'h34);
    hostWrite(3'd7, 8'h00);
    readChk("R2 back to general", 3'd1, 8'h3C);
    chk("R4 divisor kept", divisor, 16'h1234);
  endtask

  task automatic testTx;
    logic [7:0] d;
    logic v;
    for (int i = 0; i < 3; i++) hostWrite(3'd0, 8'h10 + 8'(i));
    readChk("R7 status tx partial", 3'd5, 8'h20);
    hostWrite(3'd7, 8'h01);
    readChk("R8 txFree 125", 3'd5, 125);
    hostWrite(3'd5, 8'hFF);
    hostWrite(3'd6, 8'hFF);
    readChk("R8 write ignored txFree", 3'd5, 125);
    readChk("R8 write ignored rxCount", 3'd6, 0);
    for (int i = 0; i < 3; i++) begin
      linePop(d, v);
      chk("R5 tx order", d, 8'h10 + i);
      chk("R5 tx valid", v, 1);
    end
    chk("R5 tx drained", txOutValid, 0);
    for (int i = 0; i < 128; i++) hostWrite(3'd0, 8'(i * 3));
    readChk("R11 txFree full", 3'd5, 0);
    hostWrite(3'd0, 8'hEE);
    readChk("R5 overflow dropped", 3'd5, 0);
    hostWrite(3'd7, 8'h00);
    readChk("R7 status tx full", 3'd5, 8'h00);
    for (int i = 0; i < 128; i++) begin
      linePop(d, v);
      chk("R5 full drain order", d, (i * 3) & 8'hFF);
    end
    chk("R5 overflow byte absent", txOutValid, 0);
  endtask

  task automatic testRx;
    logic [7:0] d;
    linePush(8'h81);
    linePush(8'h82);
    readChk("R7 status rx", 3'd5, 8'h61);
    hostWrite(3'd7, 8'h01);
    readChk("R8 rxCount 2", 3'd6, 2);
    readChk("R6 rx first", 3'd0, 8'h81);
    readChk("R6 rx second", 3'd0, 8'h82);
    readChk("R6 rx empty read", 3'd0, 8'h00);
    readChk("R6 rx count zero", 3'd6, 0);
    for (int i = 0; i < 129; i++) linePush(8'(i + 7));
    readChk("R11 rxCount full", 3'd6, 128);
    hostWrite(3'd7, 8'h00);
    readChk("R7 status rx full", 3'd5, 8'h63);
    for (int i = 0; i < 128; i++) begin
      hostRead(3'd0, d);
      chk("R6 rx drain order", d, (i + 7) & 8'hFF);
    end
    readChk("R6 overflow byte absent", 3'd0, 8'h00);
  endtask

  task automatic testBanks;
    hostWrite(3'd7, 8'h03);
    readChk("R9 ext1 addr5", 3'd5, 8'h00);
    readChk("R9 ext1 addr6", 3'd6, 8'h00);
    hostWrite(3'd7, 8'h05);
    readChk("R9/R10 ext2 addr5", 3'd5, 8'h00);
    readChk("R10 ext2 addr0", 3'd0, 8'h00);
    hostWrite(3'd0, 8'h55);
    hostWrite(3'd1, 8'h66);
    hostWrite(3'd7, 8'h06);
    readChk("R10 rsvd addr0", 3'd0, 8'h00);
    readChk("R10 rsvd addr1", 3'd1, 8'h00);
    readChk("R2 rsvd addr7", 3'd7, 8'h00);
    hostWrite(3'd0, 8'h99);
    hostWrite(3'd1, 8'h77);
    chk("R10 divisor untouched", divisor, 16'h1234);
    chk("R10 tx untouched", txOutValid, 0);
    hostWrite(3'd7, 8'h00);
    readChk("R10 scratch untouched", 3'd1, 8'h3C);
    readChk("R10 rx untouched", 3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testScratch();
    testDivisor();
    testTx();
    testRx();
    testBanks();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule